// File: doc/BRIEF.md
# Six-Channel PWM Generator with Triggered Commit

This block produces six pulse-width modulated outputs. Each channel is configured through a small word-addressed register bus. The configuration covers a period length, a high-time length, a clock prescaler and an output polarity. Bus writes only land in shadow copies. A channel's generator adopts its shadow settings only when that channel's commit bit goes from 0 to 1.

At that edge the channel's pacing bit picks one of two timings. With pacing set, the hand-over waits for the running period to finish, so the waveform never shows a torn period. With pacing clear, the new settings start after a fixed latency, `LAT_CYC` clock cycles long, and the period counter restarts.

There is no enable bit. Software turns a channel off by committing a high time of zero. While a channel's commit and pacing bits are both 0, its output is held high. A clock-enable input stops all six generators, and each output keeps the level it had at that moment.

Top module: `tpwm_ctrl`

## Requirements
- R1: The control word at byte offset 0x00 holds, for channel n, the commit bit at bit n, the polarity bit at bit 8+n, a stored-only drive-type bit at bit 16+n and the pacing bit at bit 24+n. All other bits read as 0.
- R2: Offset 0x04 holds a 3-bit prescale field for channel n at bits 4n+2..4n. A channel's period counter advances once every (prescale+1) clocks, so one period lasts period×(prescale+1) clocks. Undefined bits read as 0.
- R3: Channel n's period length sits at 0x08+8n and its high-time length at 0x0C+8n. Both are 24 bits wide, and reads return the written values masked to 24 bits.
- R4: Writes to prescale, period, high time or polarity leave the output unchanged until that channel's commit bit rises from 0 to 1.
- R5: With pacing at 1 at the commit edge, the running waveform continues unchanged until its current period ends, and the new settings take over at that boundary.
- R6: With pacing at 0 at the commit edge, the new settings take over LAT_CYC clocks after the edge is seen, and the period starts afresh.
- R7: While a channel's commit and pacing bits are both 0, its output is 1.
- R8: A committed high time of 0 with polarity 1 gives a constant 0 output.
- R9: With polarity 1, the output is 1 for the first high-time counts of each period and 0 for the rest. Polarity 0 inverts this.
- R10: While clk_en is 0, every output and every generator holds its state.
- R11: A committed high time equal to or above the period length keeps the output active for the whole period.
- R12: Writes to offsets at or above 0x38 change no register, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_en | input | 1 | Generator clock enable; 0 freezes every channel |
| bus_addr | input | 8 | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_rdata | output | 32 | Read data for bus_addr (shadow values) |
| pwm_o | output | 6 | PWM outputs, bit n for channel n |

## Verification
The bench counts active cycles over exactly one period for several mixes of prescale, period, high time and polarity. A wrong divider or an inverted polarity therefore shows up as a wrong count. It also commits a paced update in the middle of a long high phase. A design that applied that update at once would cut the high phase short within the next 60 cycles.

It also covers the edges of the high-time range. High time 0 must give a steady 0, and a high time at or above the period must give a steady 1. A design that clipped either comparison would let a pulse slip through.

Further tests write shadow values without a commit, which a leaky design would show on the output at once. Others clear both control bits, where the output must go high, and stop the clock enable, where a free-running counter would make the outputs toggle.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;
  // update sequencing phase of one channel
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_EDGE = 2'd1,  // waiting for the period boundary
    PH_LAT  = 2'd2   // waiting out the fixed latency
  } upd_ph_e;
endpackage

// File: rtl/tpwm_regs.sv
module tpwm_regs #(
  parameter int NCH = 6,
  parameter int CW  = 24,
  parameter int PW  = 3,
  parameter int AW  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           addr,
  input  logic [31:0]             wdata,
  input  logic                    we,
  output logic [31:0]             rdata,
  output logic [NCH-1:0]          trig,
  output logic [NCH-1:0]          pol,
  output logic [NCH-1:0]          smooth,
  output logic [NCH-1:0][PW-1:0]  pre,
  output logic [NCH-1:0][CW-1:0]  per,
  output logic [NCH-1:0][CW-1:0]  duty
);
  localparam int IDXW = AW - 2;
  localparam int NREG = 2 + 2 * NCH;

  logic [NCH-1:0]         trig_r, trig_n, pol_r, pol_n, typ_r, typ_n, smo_r, smo_n;
  logic [NCH-1:0][PW-1:0] pre_r, pre_n;
  logic [NCH-1:0][CW-1:0] per_r, per_n, duty_r, duty_n;
  logic [IDXW-1:0]        idx;
  logic                   unused_bits;

  assign idx         = addr[AW-1:2];
  assign unused_bits = ^{addr[1:0], wdata};

  always_comb begin
    trig_n = trig_r;
    pol_n  = pol_r;
    typ_n  = typ_r;
    smo_n  = smo_r;
    pre_n  = pre_r;
    per_n  = per_r;
    duty_n = duty_r;
    if (we) begin
      if (idx == IDXW'(0)) begin
        trig_n = wdata[0 +: NCH];
        pol_n  = wdata[8 +: NCH];
        typ_n  = wdata[16 +: NCH];
        smo_n  = wdata[24 +: NCH];
      end
      for (int c = 0; c < NCH; c++) begin
        if (idx == IDXW'(1))       pre_n[c]  = wdata[4*c +: PW];
        if (idx == IDXW'(2 + 2*c)) per_n[c]  = wdata[CW-1:0];
        if (idx == IDXW'(3 + 2*c)) duty_n[c] = wdata[CW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_r <= '0;
      pol_r  <= '0;
      typ_r  <= '0;
      smo_r  <= '0;
      pre_r  <= '0;
      per_r  <= '0;
      duty_r <= '0;
    end else begin
      trig_r <= trig_n;
      pol_r  <= pol_n;
      typ_r  <= typ_n;
      smo_r  <= smo_n;
      pre_r  <= pre_n;
      per_r  <= per_n;
      duty_r <= duty_n;
    end
  end

  // read path returns shadow contents
  always_comb begin
    rdata = '0;
    if (idx == IDXW'(0)) begin
      rdata[0 +: NCH]  = trig_r;
      rdata[8 +: NCH]  = pol_r;
      rdata[16 +: NCH] = typ_r;
      rdata[24 +: NCH] = smo_r;
    end
    for (int c = 0; c < NCH; c++) begin
      if (idx == IDXW'(1))       rdata[4*c +: PW] = pre_r[c];
      if (idx == IDXW'(2 + 2*c)) rdata[CW-1:0]    = per_r[c];
      if (idx == IDXW'(3 + 2*c)) rdata[CW-1:0]    = duty_r[c];
    end
  end

  assign trig   = trig_r;
  assign pol    = pol_r;
  assign smooth = smo_r;
  assign pre    = pre_r;
  assign per    = per_r;
  assign duty   = duty_r;

  // R12: an out-of-map write leaves every register alone
  a_r12_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we && idx >= IDXW'(NREG)) |=> ($stable({trig_r, pol_r, typ_r, smo_r}) &&
                                    $stable(pre_r) && $stable(per_r) && $stable(duty_r)));
endmodule

// File: rtl/tpwm_chan.sv
module tpwm_chan
  import tpwm_pkg::*;
#(
  parameter int CW  = 24,
  parameter int PW  = 3,
  parameter int LAT = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          trig,
  input  logic          smooth,
  input  logic          pol_s,
  input  logic [PW-1:0] pre_s,
  input  logic [CW-1:0] per_s,
  input  logic [CW-1:0] duty_s,
  output logic          pwm
);
  localparam int LW = $clog2(LAT + 1);

  upd_ph_e       ph_q, ph_n;
  logic [LW-1:0] lat_q, lat_n;
  logic          trig_q;
  logic          stg_pol_q, stg_pol_n, act_pol_q, act_pol_n;
  logic [PW-1:0] stg_pre_q, stg_pre_n, act_pre_q, act_pre_n, pre_cnt_q, pre_cnt_n;
  logic [CW-1:0] stg_per_q, stg_per_n, act_per_q, act_per_n;
  logic [CW-1:0] stg_duty_q, stg_duty_n, act_duty_q, act_duty_n;
  logic [CW-1:0] per_cnt_q, per_cnt_n;
  logic          pwm_q, pwm_n;
  logic          rise, tick, last, boundary, commit, level;

  always_comb begin
    rise     = trig & ~trig_q;
    tick     = (pre_cnt_q == act_pre_q);
    last     = (act_per_q <= CW'(1)) || (per_cnt_q >= act_per_q - CW'(1));
    boundary = tick && last;
    commit   = ((ph_q == PH_EDGE) && boundary) ||
               ((ph_q == PH_LAT) && (lat_q == LW'(1)));
    level    = (per_cnt_q < act_duty_q) ? act_pol_q : ~act_pol_q;

    ph_n       = ph_q;
    lat_n      = lat_q;
    stg_pol_n  = stg_pol_q;
    stg_pre_n  = stg_pre_q;
    stg_per_n  = stg_per_q;
    stg_duty_n = stg_duty_q;
    act_pol_n  = act_pol_q;
    act_pre_n  = act_pre_q;
    act_per_n  = act_per_q;
    act_duty_n = act_duty_q;
    pre_cnt_n  = pre_cnt_q;
    per_cnt_n  = per_cnt_q;

    if (ph_q == PH_LAT && lat_q != '0) lat_n = lat_q - LW'(1);

    if (commit) begin
      ph_n       = PH_IDLE;
      act_pol_n  = stg_pol_q;
      act_pre_n  = stg_pre_q;
      act_per_n  = stg_per_q;
      act_duty_n = stg_duty_q;
      pre_cnt_n  = '0;
      per_cnt_n  = '0;
    end else if (tick) begin
      pre_cnt_n = '0;
      per_cnt_n = last ? '0 : per_cnt_q + CW'(1);
    end else begin
      pre_cnt_n = pre_cnt_q + PW'(1);
    end

    // a new edge restarts sequencing with a fresh snapshot
    if (rise) begin
      ph_n       = smooth ? PH_EDGE : PH_LAT;
      lat_n      = LW'(LAT);
      stg_pol_n  = pol_s;
      stg_pre_n  = pre_s;
      stg_per_n  = per_s;
      stg_duty_n = duty_s;
    end

    pwm_n = (!smooth && !trig) ? 1'b1 : level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q       <= PH_IDLE;
      lat_q      <= '0;
      trig_q     <= 1'b0;
      stg_pol_q  <= 1'b0;
      stg_pre_q  <= '0;
      stg_per_q  <= '0;
      stg_duty_q <= '0;
      act_pol_q  <= 1'b0;
      act_pre_q  <= '0;
      act_per_q  <= '0;
      act_duty_q <= '0;
      pre_cnt_q  <= '0;
      per_cnt_q  <= '0;
      pwm_q      <= 1'b1;
    end else if (ce) begin
      ph_q       <= ph_n;
      lat_q      <= lat_n;
      trig_q     <= trig;
      stg_pol_q  <= stg_pol_n;
      stg_pre_q  <= stg_pre_n;
      stg_per_q  <= stg_per_n;
      stg_duty_q <= stg_duty_n;
      act_pol_q  <= act_pol_n;
      act_pre_q  <= act_pre_n;
      act_per_q  <= act_per_n;
      act_duty_q <= act_duty_n;
      pre_cnt_q  <= pre_cnt_n;
      per_cnt_q  <= per_cnt_n;
      pwm_q      <= pwm_n;
    end
  end

  assign pwm = pwm_q;

  // R7: both control bits low drive the output high
  a_r7_forced_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !smooth && !trig) |=> pwm);
  // R10: a stopped clock enable freezes output and counters
  a_r10_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(pwm) && $stable(per_cnt_q) && $stable(pre_cnt_q)));
  // R4: with no update in flight and no new edge, active settings hold
  a_r4_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE && !rise) |=> ($stable(act_per_q) && $stable(act_duty_q) &&
                                   $stable(act_pre_q) && $stable(act_pol_q)));
  // R6: latency counter never exceeds its load value
  a_r6_lat_bound: assert property (@(posedge clk) disable iff (!rst_n)
    lat_q <= LW'(LAT));
  // R8: zero high time with normal polarity stays inactive
  a_r8_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && act_duty_q == '0 && act_pol_q && (trig || smooth)) |=> !pwm);
  // R11: high time at or above the period stays active
  a_r11_full_on: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && act_pol_q && act_per_q != '0 && act_duty_q >= act_per_q && (trig || smooth)) |=> pwm);
endmodule

// File: rtl/tpwm_ctrl.sv
module tpwm_ctrl #(
  parameter int NCH     = 6,
  parameter int CNT_W   = 24,
  parameter int PRE_W   = 3,
  parameter int LAT_CYC = 40,
  parameter int AW      = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clk_en,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  input  logic            bus_we,
  output logic [31:0]     bus_rdata,
  output logic [NCH-1:0]  pwm_o
);
  logic [1:0]                   rst_pipe_q;
  logic                         rst_sync_n;
  logic [NCH-1:0]               trig, pol, smooth;
  logic [NCH-1:0][PRE_W-1:0]    pre;
  logic [NCH-1:0][CNT_W-1:0]    per, duty;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  tpwm_regs #(.NCH(NCH), .CW(CNT_W), .PW(PRE_W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .addr(bus_addr), .wdata(bus_wdata), .we(bus_we),
    .rdata(bus_rdata), .trig(trig), .pol(pol), .smooth(smooth),
    .pre(pre), .per(per), .duty(duty)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tpwm_chan #(.CW(CNT_W), .PW(PRE_W), .LAT(LAT_CYC)) u_ch (
      .clk(clk), .rst_n(rst_sync_n), .ce(clk_en), .trig(trig[g]), .smooth(smooth[g]),
      .pol_s(pol[g]), .pre_s(pre[g]), .per_s(per[g]), .duty_s(duty[g]), .pwm(pwm_o[g])
    );
  end
endmodule

// File: tb/tpwm_ctrl_test.sv
module tpwm_ctrl_test;
  localparam int LAT = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [5:0]  pwm_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [31:0] ctrl_sh = '0;
  logic [31:0] pre_sh = '0;

  always #5 clk = ~clk;

  tpwm_ctrl #(.LAT_CYC(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata), .pwm_o(pwm_o)
  );

  typedef struct packed {
    logic [3:0]  ch;
    logic [3:0]  pre;
    logic        pol;
    logic [15:0] per;
    logic [15:0] duty;
    logic [15:0] hi;
  } vec_t;

  // channel, prescale, polarity, period, high time, expected active cycles per period
  localparam vec_t TBL [7] = '{
    '{4'd0, 4'd0, 1'b1, 16'd10, 16'd3, 16'd3},   // R9 normal
    '{4'd1, 4'd2, 1'b1, 16'd6,  16'd2, 16'd6},   // R2 divide by 3
    '{4'd2, 4'd0, 1'b0, 16'd8,  16'd3, 16'd5},   // R9 inverted
    '{4'd3, 4'd1, 1'b1, 16'd5,  16'd0, 16'd0},   // R8 zero high time
    '{4'd4, 4'd0, 1'b1, 16'd4,  16'd9, 16'd4},   // R11 above period
    '{4'd5, 4'd7, 1'b1, 16'd2,  16'd1, 16'd8},   // R2 divide by 8
    '{4'd0, 4'd0, 1'b1, 16'd7,  16'd7, 16'd7}    // R11 equal to period
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic measure(input int ch, input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cnt += int'(pwm_o[ch]);
    end
  endtask

  task automatic commit(input int ch, input bit sm);
    ctrl_sh[24+ch] = 1'b1; ctrl_sh[ch] = 1'b0;
    wr(8'h00, ctrl_sh);
    ctrl_sh[ch] = 1'b1; ctrl_sh[24+ch] = sm;
    wr(8'h00, ctrl_sh);
  endtask

  task automatic cfg(input int ch, input int pre, input int per, input int duty, input bit pol);
    wr(8'(8 + 8*ch), 32'(per));
    wr(8'(12 + 8*ch), 32'(duty));
    pre_sh[4*ch +: 3] = 3'(pre);
    wr(8'h04, pre_sh);
    ctrl_sh[8+ch] = pol;
    wr(8'h00, ctrl_sh);
    commit(ch, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int cnt;
    int mism;
    logic [5:0] snap;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state (R7, R1, R3)
    chk("R7 reset outputs high", 32'(pwm_o), 32'h3f);
    rd(8'h00, v); chk("R1 reset control", v, 32'h0);
    rd(8'h08, v); chk("R3 reset period", v, 32'h0);

    // R1 layout and masking
    wr(8'h00, 32'hFFFF_FF00);
    rd(8'h00, v); chk("R1 control readback", v, 32'h3F3F_3F00);
    wr(8'h00, 32'h0);

    // R2 prescale fields
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, v); chk("R2 prescale readback", v, 32'h0077_7777);
    wr(8'h04, 32'h0);

    // R3 count registers are 24 bits
    wr(8'h08, 32'hABCD_EF12);
    rd(8'h08, v); chk("R3 period width", v, 32'h00CD_EF12);
    wr(8'h34, 32'h1234_5678);
    rd(8'h34, v); chk("R3 high time width", v, 32'h0034_5678);

    // R12 unmapped offsets
    wr(8'h38, 32'hFFFF_FFFF);
    rd(8'h38, v); chk("R12 unmapped read", v, 32'h0);
    rd(8'h34, v); chk("R12 neighbour intact", v, 32'h0034_5678);
    rd(8'h00, v); chk("R12 control intact", v, 32'h0);

    // vector table: one full period per entry
    foreach (TBL[k]) begin
      cfg(int'(TBL[k].ch), int'(TBL[k].pre), int'(TBL[k].per), int'(TBL[k].duty), TBL[k].pol);
      repeat (LAT + 10) @(negedge clk);
      measure(int'(TBL[k].ch), int'(TBL[k].per) * (int'(TBL[k].pre) + 1), cnt);
      chk($sformatf("R9/R2/R8/R11 vector %0d", k), 32'(cnt), 32'(TBL[k].hi));
    end

    // R4: shadow write without an edge leaves channel 0 at 7 of 7
    wr(8'h0C, 32'd2);
    repeat (LAT + 10) @(negedge clk);
    measure(0, 7, cnt); chk("R4 no commit no change", 32'(cnt), 32'd7);

    // R6: immediate commit applies the new high time
    commit(0, 1'b0);
    repeat (LAT + 10) @(negedge clk);
    measure(0, 7, cnt); chk("R6 immediate commit", 32'(cnt), 32'd2);

    // R5: paced commit waits out the current period
    cfg(1, 0, 200, 100, 1'b1);
    repeat (LAT + 10) @(negedge clk);
    for (int i = 0; i < 400 && pwm_o[1] !== 1'b0; i++) @(negedge clk);
    for (int i = 0; i < 400 && pwm_o[1] !== 1'b1; i++) @(negedge clk);
    wr(8'h14, 32'd20);
    commit(1, 1'b1);
    measure(1, 60, cnt); chk("R5 old waveform kept", 32'(cnt), 32'd60);
    repeat (200) @(negedge clk);
    measure(1, 200, cnt); chk("R5 new waveform after boundary", 32'(cnt), 32'd20);

    // R7: clear both bits of channel 2 (inverted, 5 of 8 otherwise)
    ctrl_sh[2] = 1'b0; ctrl_sh[26] = 1'b0;
    wr(8'h00, ctrl_sh);
    repeat (3) @(negedge clk);
    measure(2, 16, cnt); chk("R7 forced high", 32'(cnt), 32'd16);

    // R10: clock enable low freezes all outputs
    @(negedge clk);
    clk_en = 1'b0;
    @(negedge clk);
    snap = pwm_o;
    mism = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (pwm_o !== snap) mism++;
    end
    clk_en = 1'b1;
    chk("R10 outputs frozen", 32'(mism), 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule